// File: doc/BRIEF.md
# Prioritized UART Interrupt Encoder

This block sits between the condition sources of one UART channel and its host interface. It takes seven interrupt conditions: receive line error, receive data at trigger, receive time-out, transmit holding empty, modem status change, Xoff/special-character match, and a flow-control pin change. It masks each condition with its enable bit and reports only the most urgent one as an encoded status byte. It also drives the channel's interrupt request line.

Most sources are levels owned by neighbouring logic. Two sources are held here as sticky flags. The transmit-empty flag is set by a pulse and cleared by a transmit-holding write, or by a status read that reports it. The flow-pin flag is set on a rising edge of the CTS or RTS pin and cleared by a status read that reports it.

The status byte is frozen on the first cycle of a host read strobe. The value the host samples therefore cannot change mid-read. A source that arrives during the read stays pending and is reported afterwards.

Top module: `uart_irq_enc`

## Requirements
- R1: isr_o[0] is 0 when a source is pending and 1 when none is. With nothing pending, isr_o[5:0] reads 0x01.
- R2: Source codes in isr_o[5:0] are as follows. Line error 0x06. Receive data 0x04. Receive time-out 0x0C. Transmit empty 0x02. Modem change 0x00. Xoff/special 0x10. Flow-pin change 0x20.
- R3: Receive data and receive time-out share one priority level. When both are present, 0x04 is reported.
- R4: Only the highest pending source is reported. Priority runs line error, receive data/time-out, transmit empty, modem change, Xoff/special, and flow-pin change lowest. A lower source appears once the higher ones are gone.
- R5: isr_o[7:6] reads 11 when fifo_en_i is 1 and 00 otherwise.
- R6: The Xoff/special source (ier_i[5]) and the flow-pin source take part only when enh_en_i is 1. Otherwise isr_o[5:4] stays 00.
- R7: The transmit-empty flag is set by thr_empty_i. It is cleared by thr_wr_i, or by the first cycle of a status read that reports 0x02. A set in the same cycle as a clear wins.
- R8: The flow-pin flag is set on a low-to-high transition of cts_i (when ier_i[7]=1) or rts_i (when ier_i[6]=1), in enhanced mode only. A falling edge has no effect. The flag is cleared by the first cycle of a status read that reports 0x20.
- R9: While isr_rd_i stays high, isr_o holds the value it showed in the strobe's first cycle. After the strobe falls, isr_o shows the live status again.
- R10: irq_o is 1 exactly when irq_oe_i is 1 and a source is pending. It follows the live status even during a read.
- R11: Enable bits are as follows. ier_i[0] covers receive data and time-out. ier_i[1] covers transmit empty. ier_i[2] covers line error. ier_i[3] covers modem change. A source whose enable is 0 is never reported.
- R12: After reset both sticky flags are clear and isr_o reads {fifo bits, 0x01}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 8 | Interrupt enable register |
| fifo_en_i | input | 1 | FIFOs enabled |
| enh_en_i | input | 1 | Enhanced mode enabled |
| irq_oe_i | input | 1 | Interrupt output enable |
| line_err_i | input | 1 | Receive line error pending (level) |
| rx_data_i | input | 1 | Receive data at trigger (level) |
| rx_tmo_i | input | 1 | Receive time-out (level) |
| thr_empty_i | input | 1 | Transmit holding became empty (pulse) |
| thr_wr_i | input | 1 | Host write to transmit holding register |
| modem_chg_i | input | 1 | Modem status change pending (level) |
| xoff_det_i | input | 1 | Xoff or special character detected (level) |
| cts_i | input | 1 | CTS pin state |
| rts_i | input | 1 | RTS pin state |
| isr_rd_i | input | 1 | Host read strobe of the status register |
| isr_o | output | 8 | Encoded interrupt status |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land in the same cycle here. A status read's leading edge can coincide with a change among the pending sources. A transmit-holding write can also coincide with a new empty pulse. The bench drives sources that appear or vanish while the strobe is held, and fires clear and set together on the transmit-empty flag. It judges the frozen byte against the live interrupt line and confirms that no pending source is lost. A bench-side model predicts every cycle's status byte and request level, and these are compared under both directed and random traffic.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC  = 7;
  localparam int IDX_W = $clog2(NSRC);

  // index order is priority order, 0 = highest
  typedef enum logic [IDX_W-1:0] {
    SRC_LINE  = 3'd0,
    SRC_RXDAT = 3'd1,
    SRC_RXTMO = 3'd2,
    SRC_THRE  = 3'd3,
    SRC_MODEM = 3'd4,
    SRC_XOFF  = 3'd5,
    SRC_FLOW  = 3'd6
  } src_e;

  localparam logic [5:0] CODE_NONE = 6'h01;
  localparam logic [5:0] CODE_THRE = 6'h02;
  localparam logic [5:0] CODE_FLOW = 6'h20;

  function automatic logic [5:0] src_code(input logic [IDX_W-1:0] idx);
    case (idx)
      SRC_LINE:  return 6'h06;
      SRC_RXDAT: return 6'h04;
      SRC_RXTMO: return 6'h0C;
      SRC_THRE:  return CODE_THRE;
      SRC_MODEM: return 6'h00;
      SRC_XOFF:  return 6'h10;
      SRC_FLOW:  return CODE_FLOW;
      default:   return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // new event beats a clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N   = 7,
  parameter int W   = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/uart_irq_enc.sv
module uart_irq_enc
  import uart_irq_pkg::*;
#(
  parameter int NPIN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ier_i,
  input  logic       fifo_en_i,
  input  logic       enh_en_i,
  input  logic       irq_oe_i,
  input  logic       line_err_i,
  input  logic       rx_data_i,
  input  logic       rx_tmo_i,
  input  logic       thr_empty_i,
  input  logic       thr_wr_i,
  input  logic       modem_chg_i,
  input  logic       xoff_det_i,
  input  logic       cts_i,
  input  logic       rts_i,
  input  logic       isr_rd_i,
  output logic [7:0] isr_o,
  output logic       irq_o
);
  logic [NPIN-1:0] pin_now, pin_en, pin_rise;
  logic            rd_q, rd_lead;
  logic [7:0]      snap_q, live;
  logic            thre_q, flow_q, flow_set;
  logic [NSRC-1:0] req;
  logic            pend;
  logic [IDX_W-1:0] win;
  logic [5:0]      code;

  assign pin_now = {rts_i, cts_i};
  assign pin_en  = {ier_i[6], ier_i[7]};

  // per-pin rising-edge detect, previous level resets high
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= pin_now[g];
    end
    assign pin_rise[g] = pin_now[g] & ~prev_q & pin_en[g];
  end

  assign flow_set = enh_en_i & (|pin_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= isr_rd_i;
  end
  assign rd_lead = isr_rd_i & ~rd_q;

  uart_irq_flag u_thre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (thr_empty_i),
    .clr_i (thr_wr_i | (rd_lead & pend & (code == CODE_THRE))),
    .q_o   (thre_q)
  );

  uart_irq_flag u_flow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flow_set),
    .clr_i (rd_lead & pend & (code == CODE_FLOW)),
    .q_o   (flow_q)
  );

  always_comb begin
    req            = '0;
    req[SRC_LINE]  = ier_i[2] & line_err_i;
    req[SRC_RXDAT] = ier_i[0] & rx_data_i;
    req[SRC_RXTMO] = ier_i[0] & rx_tmo_i;
    req[SRC_THRE]  = ier_i[1] & thre_q;
    req[SRC_MODEM] = ier_i[3] & modem_chg_i;
    req[SRC_XOFF]  = enh_en_i & ier_i[5] & xoff_det_i;
    req[SRC_FLOW]  = enh_en_i & flow_q;
  end

  uart_irq_prio #(.N(NSRC), .W(IDX_W)) u_prio (
    .req_i  (req),
    .valid_o(pend),
    .idx_o  (win)
  );

  assign code = pend ? src_code(win) : CODE_NONE;
  assign live = {{2{fifo_en_i}}, code};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= {2'b00, CODE_NONE};
    else if (rd_lead) snap_q <= live;
  end

  assign isr_o = (isr_rd_i & rd_q) ? snap_q : live;
  assign irq_o = irq_oe_i & pend;
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ier_i,
  input logic       fifo_en_i,
  input logic       enh_en_i,
  input logic       irq_oe_i,
  input logic       line_err_i,
  input logic       thr_empty_i,
  input logic       thr_wr_i,
  input logic       isr_rd_i,
  input logic [7:0] isr_o,
  input logic       irq_o
);
  assert_irq_mirror_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_oe_i && !isr_rd_i) |-> (irq_o == !isr_o[0]));

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_oe_i |-> !irq_o);

  assert_fifo_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isr_rd_i |-> (isr_o[7:6] == {2{fifo_en_i}}));

  assert_enh_hidden_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enh_en_i && !isr_rd_i) |-> (isr_o[5:4] == 2'b00));

  assert_line_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i[2] && line_err_i && !isr_rd_i) |-> (isr_o[5:0] == 6'h06));

  assert_read_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(isr_rd_i) && isr_rd_i) |-> $stable(isr_o));

  assert_thre_wr_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !thr_empty_i) |=> (isr_rd_i || isr_o[5:0] != 6'h02));
endmodule

bind uart_irq_enc uart_irq_chk u_chk (.*);

// File: tb/tb_uart_irq_enc.sv
`timescale 1ns/1ps
module tb_uart_irq_enc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ier;
  logic       fifo, enh, oe, line_err, rx_data, rx_tmo, thr_empty, thr_wr;
  logic       modem, xoff, cts, rts, rd;
  logic [7:0] isr_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  logic       m_thre, m_flow, m_cts_p, m_rts_p, m_rd_p;
  logic [7:0] m_snap;

  always #10 clk = ~clk;

  uart_irq_enc dut (
    .clk_i(clk), .rst_ni(rst_n), .ier_i(ier), .fifo_en_i(fifo), .enh_en_i(enh),
    .irq_oe_i(oe), .line_err_i(line_err), .rx_data_i(rx_data), .rx_tmo_i(rx_tmo),
    .thr_empty_i(thr_empty), .thr_wr_i(thr_wr), .modem_chg_i(modem),
    .xoff_det_i(xoff), .cts_i(cts), .rts_i(rts), .isr_rd_i(rd),
    .isr_o(isr_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] live_f();
    logic [5:0] c;
    if      (ier[2] && line_err)        c = 6'h06;
    else if (ier[0] && rx_data)         c = 6'h04;
    else if (ier[0] && rx_tmo)          c = 6'h0C;
    else if (ier[1] && m_thre)          c = 6'h02;
    else if (ier[3] && modem)           c = 6'h00;
    else if (enh && ier[5] && xoff)     c = 6'h10;
    else if (enh && m_flow)             c = 6'h20;
    else                                c = 6'h01;
    return {{2{fifo}}, c};
  endfunction

  task automatic step(input string tag);
    logic [7:0] lv, ex;
    logic       exq, lead, fset;
    #2;
    lv  = live_f();
    ex  = (rd && m_rd_p) ? m_snap : lv;
    exq = oe && !lv[0];
    n_chk++;
    if (isr_o !== ex) begin
      n_bad++;
      $display("FAIL %s isr_o act=%h exp=%h", tag, isr_o, ex);
    end
    n_chk++;
    if (irq_o !== exq) begin
      n_bad++;
      $display("FAIL %s irq_o act=%b exp=%b", tag, irq_o, exq);
    end
    @(posedge clk);
    lead = rd && !m_rd_p;
    if (lead) m_snap = lv;
    if (thr_empty) m_thre = 1'b1;
    else if (thr_wr || (lead && lv[5:0] == 6'h02)) m_thre = 1'b0;
    fset = enh && ((cts && !m_cts_p && ier[7]) || (rts && !m_rts_p && ier[6]));
    if (fset) m_flow = 1'b1;
    else if (lead && lv[5:0] == 6'h20) m_flow = 1'b0;
    m_cts_p = cts;
    m_rts_p = rts;
    m_rd_p  = rd;
    @(negedge clk);
  endtask

  task automatic quiet();
    line_err = 0; rx_data = 0; rx_tmo = 0; thr_empty = 0; thr_wr = 0;
    modem = 0; xoff = 0; rd = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; ier = 8'h00; fifo = 0; enh = 0; oe = 1; cts = 0; rts = 0;
    quiet();
    m_thre = 0; m_flow = 0; m_cts_p = 1; m_rts_p = 1; m_rd_p = 0;
    m_snap = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R12 reset state");
    step("R1 idle reads 0x01");
    fifo = 1; step("R5 fifo bits set");
    fifo = 0; step("R5 fifo bits clear");
    fifo = 1;

    ier = 8'h0F; line_err = 1; step("R2 line error code");
    rx_data = 1; step("R4 line beats rx data");
    line_err = 0; step("R4 rx data after line clears");
    rx_tmo = 1; step("R3 data and timeout share level");
    rx_data = 0; step("R3 timeout code");
    rx_tmo = 0; step("R1 back to idle");

    thr_empty = 1; step("R7 empty pulse");
    thr_empty = 0; step("R7 transmit empty reported");
    rd = 1; step("R7 read reports 0x02");
    step("R9 held during read");
    line_err = 1; step("R9 frozen while source arrives");
    rd = 0; step("R9 live after read");
    line_err = 0; step("R7 cleared by read");
    thr_empty = 1; step("R7 set again");
    thr_empty = 0; thr_wr = 1; step("R7 write clears");
    thr_wr = 0; step("R7 after write");
    thr_empty = 1; thr_wr = 1; step("R7 set wins over clear");
    thr_empty = 0; thr_wr = 0; step("R7 set won");
    modem = 1; step("R4 thre beats modem");
    thr_wr = 1; step("R4 modem shows after thre clear");
    thr_wr = 0; step("R2 modem code");
    oe = 0; step("R10 output gated off");
    oe = 1; modem = 0;

    ier = 8'hFF; xoff = 1; step("R6 xoff hidden w/o enhanced");
    enh = 1; step("R6 xoff in enhanced");
    xoff = 0; cts = 1; step("R8 cts rising");
    step("R8 flow flag reported");
    cts = 0; step("R8 falling edge no effect");
    rd = 1; step("R8 read reports 0x20");
    step("R8 hold");
    rd = 0; step("R8 cleared by read");
    ier = 8'h40; rts = 1; step("R8 rts rising");
    step("R8 rts flag reported");
    ier = 8'h00; rts = 0; step("R11 masked flow still sticky");
    line_err = 1; rx_data = 1; modem = 1; step("R11 masked sources ignored");
    quiet(); rd = 1; step("R9 read with nothing pending");
    line_err = 1; ier = 8'h04; step("R10 irq live during read");
    rd = 0; step("R9 release shows line error");
    quiet();

    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 8) == 0) ier = 8'($urandom);
      if (($urandom % 16) == 0) fifo = ~fifo;
      if (($urandom % 32) == 0) enh = ~enh;
      if (($urandom % 32) == 0) oe = ~oe;
      line_err  = (($urandom % 6) == 0);
      rx_data   = (($urandom % 4) == 0);
      rx_tmo    = (($urandom % 5) == 0);
      thr_empty = (($urandom % 6) == 0);
      thr_wr    = (($urandom % 7) == 0);
      modem     = (($urandom % 4) == 0);
      xoff      = (($urandom % 4) == 0);
      if (($urandom % 3) == 0) cts = ~cts;
      if (($urandom % 3) == 0) rts = ~rts;
      if (($urandom % 4) == 0) rd = ~rd;
      step("R4 random traffic");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule